// File: doc/BRIEF.md
# Warp Branch Divergence Mask Unit

This block tracks which threads of one warp are live while the warp runs a conditional branch. Every thread in the warp issues the same instruction. With the branch, each lane sends one vote bit that says whether that lane takes the branch. Only the votes of lanes that are live at that moment count.

When the live lanes all vote the same way, the warp simply moves to the chosen path. Nothing is saved and the branch costs nothing. When the live lanes disagree, the unit saves two entries on a small stack:

- the reconvergence point, with the mask that was live before the branch;
- the fall-through path, with the mask of the lanes that voted not-taken.

The warp then runs the taken path with only the taken lanes live. Each path ends when the warp arrives at its join PC. At that point the unit pops the top entry and resumes from it. The not-taken lanes run second, and then the full pre-branch mask comes back at the reconvergence point. Divergent branches inside an already divergent path nest through the same stack. One instance serves one warp, so each warp branches independently of the others.

The issue logic presents the PC the warp has reached on `cur_pc` and pulses `step_i`. It raises `br_i` when that instruction is a branch. The unit answers, one clock later, with the PC to fetch next and the lane mask under which results may be committed.

Top module: `warp_diverge_unit`

## Requirements
- R1: After reset, `active_mask` is all ones, `next_pc` is 0 and `ovf_err` is 0.
- R2: A step that is not a branch and does not arrive at the current join PC sets `next_pc` to `cur_pc` + `PC_STEP` (4 by default) and leaves `active_mask` unchanged.
- R3: A branch is uniform-taken when every live lane has vote bit 1 (lane i is bit i, 1 means taken). Then `next_pc` becomes `br_target`, the mask is unchanged and nothing is pushed: a later arrival at `br_reconv` advances sequentially.
- R4: A branch where every live lane votes 0 sets `next_pc` to `br_fallthru`, leaves the mask unchanged and pushes nothing.
- R5: A divergent branch sets `next_pc` to `br_target` and `active_mask` to (vote AND previous mask). The new mask is never wider than the previous one.
- R6: When the taken path arrives at `br_reconv`, `next_pc` becomes `br_fallthru` and the mask becomes (NOT vote AND pre-branch mask).
- R7: When the not-taken path then arrives at `br_reconv`, `next_pc` becomes `br_reconv` and the pre-branch mask is restored.
- R8: Nested divergent branches unwind in last-in, first-out order, each restoring its own paths and masks.
- R9: Vote bits of lanes that are not live have no effect on the uniform/divergent decision or on the masks.
- R10: A divergent branch that would grow the stack beyond `DEPTH` entries does not push. It sets `ovf_err`, leaves the mask unchanged and sets `next_pc` to `br_fallthru`.
- R11: `ovf_err` is sticky: once set, it stays at 1 until reset.
- R12: Arriving at the join PC takes precedence over a branch strobe in the same step; that branch is ignored.
- R13: In a cycle without `step_i`, `next_pc`, `active_mask` and `ovf_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Warp arrives at `cur_pc` this cycle |
| br_i | input | 1 | The instruction at `cur_pc` is a conditional branch |
| cur_pc | input | PC_W | PC the warp has reached |
| br_vote | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PC_W | Taken-path PC |
| br_fallthru | input | PC_W | Not-taken-path PC |
| br_reconv | input | PC_W | Reconvergence PC of this branch |
| next_pc | output | PC_W | PC to fetch next |
| active_mask | output | LANES | Lanes allowed to commit results |
| ovf_err | output | 1 | Sticky divergence stack overflow flag |

## Verification
The bench builds the unit with 32 lanes, 32-bit PCs and a `PC_STEP` of 4. It shrinks `DEPTH` to 4, so a third nested divergence reaches the overflow path in a few steps. With 32 lanes, half-word and byte vote patterns can split a warp at two nesting levels. They also leave lanes outside the live mask whose votes contradict the live ones, which exercises R9. Unwinding after the overflow shows that the two stored levels survive the refused push intact.

// File: rtl/wdu_pkg.sv
package wdu_pkg;

    // Outcome class of one branch vote against the live mask.
    typedef enum logic [1:0] {
        BK_NONE_LIVE = 2'd0,
        BK_ALL_TAKEN = 2'd1,
        BK_ALL_FALL  = 2'd2,
        BK_SPLIT     = 2'd3
    } br_kind_e;

endpackage

// File: rtl/wdu_vote_split.sv
module wdu_vote_split
    import wdu_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] vote,
    input  logic [LANES-1:0] live,
    output logic [LANES-1:0] taken_m,
    output logic [LANES-1:0] fall_m,
    output br_kind_e         kind
);

    always_comb begin
        taken_m = vote & live;
        fall_m  = ~vote & live;
        if (live == '0)
            kind = BK_NONE_LIVE;
        else if (fall_m == '0)
            kind = BK_ALL_TAKEN;
        else if (taken_m == '0)
            kind = BK_ALL_FALL;
        else
            kind = BK_SPLIT;
    end

    // R9: the two path masks never share a lane and never leave the live set
    always_comb begin
        split_disjoint_chk: assert (((taken_m & fall_m) == '0) && (((taken_m | fall_m) & ~live) == '0));
    end

endmodule

// File: rtl/wdu_stack.sv
module wdu_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push2,
    input  logic [PC_W-1:0]  lo_pc,
    input  logic [LANES-1:0] lo_mask,
    input  logic [PC_W-1:0]  lo_join,
    input  logic [PC_W-1:0]  hi_pc,
    input  logic [LANES-1:0] hi_mask,
    input  logic [PC_W-1:0]  hi_join,
    input  logic             pop,
    output logic [PC_W-1:0]  top_pc,
    output logic [LANES-1:0] top_mask,
    output logic [PC_W-1:0]  top_join,
    output logic [SP_W-1:0]  level,
    output logic             room2
);

    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [PC_W-1:0]  pc_d   [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [LANES-1:0] mask_d [DEPTH];
    logic [PC_W-1:0]  join_q [DEPTH];
    logic [PC_W-1:0]  join_d [DEPTH];
    logic [SP_W-1:0]  sp_q, sp_d;

    assign level = sp_q;
    assign room2 = (32'(sp_q) + 2) <= DEPTH;

    // Top-of-stack read: slot sp-1.
    always_comb begin
        top_pc   = '0;
        top_mask = '0;
        top_join = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SP_W'(i + 1)) begin
                top_pc   = pc_q[i];
                top_mask = mask_q[i];
                top_join = join_q[i];
            end
        end
    end

    always_comb begin
        sp_d = sp_q;
        for (int i = 0; i < DEPTH; i++) begin
            pc_d[i]   = pc_q[i];
            mask_d[i] = mask_q[i];
            join_d[i] = join_q[i];
        end
        if (push2 && room2) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (sp_q == SP_W'(i)) begin
                    pc_d[i]   = lo_pc;
                    mask_d[i] = lo_mask;
                    join_d[i] = lo_join;
                end
                if (sp_q + SP_W'(1) == SP_W'(i)) begin
                    pc_d[i]   = hi_pc;
                    mask_d[i] = hi_mask;
                    join_d[i] = hi_join;
                end
            end
            sp_d = sp_q + SP_W'(2);
        end else if (pop && sp_q != '0) begin
            sp_d = sp_q - SP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                pc_q[i]   <= '0;
                mask_q[i] <= '0;
                join_q[i] <= '0;
            end
        end else begin
            sp_q <= sp_d;
            for (int i = 0; i < DEPTH; i++) begin
                pc_q[i]   <= pc_d[i];
                mask_q[i] <= mask_d[i];
                join_q[i] <= join_d[i];
            end
        end
    end

    // R10
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n) push2 |-> room2);

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) 32'(sp_q) <= DEPTH);

    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (sp_q != '0) && !push2);

endmodule

// File: rtl/warp_diverge_unit.sv
module warp_diverge_unit
    import wdu_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int PC_W    = 32,
    parameter int DEPTH   = 8,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             br_i,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [LANES-1:0] br_vote,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             ovf_err
);

    localparam int SP_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  join_pc;
        logic             err;
    } wstate_t;

    wstate_t st_q, st_d;

    logic [LANES-1:0] taken_m, fall_m;
    br_kind_e         kind;
    logic             push_w, pop_w, room2;
    logic [PC_W-1:0]  top_pc, top_join;
    logic [LANES-1:0] top_mask;
    logic [SP_W-1:0]  level;
    logic             at_join;

    wdu_vote_split #(.LANES(LANES)) u_split (
        .vote    (br_vote),
        .live    (st_q.mask),
        .taken_m (taken_m),
        .fall_m  (fall_m),
        .kind    (kind)
    );

    wdu_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push2    (push_w),
        .lo_pc    (br_reconv),
        .lo_mask  (st_q.mask),
        .lo_join  (st_q.join_pc),
        .hi_pc    (br_fallthru),
        .hi_mask  (fall_m),
        .hi_join  (br_reconv),
        .pop      (pop_w),
        .top_pc   (top_pc),
        .top_mask (top_mask),
        .top_join (top_join),
        .level    (level),
        .room2    (room2)
    );

    assign at_join = (level != '0) && (cur_pc == st_q.join_pc);

    always_comb begin
        st_d   = st_q;
        push_w = 1'b0;
        pop_w  = 1'b0;
        if (step_i) begin
            if (at_join) begin
                pop_w        = 1'b1;
                st_d.pc      = top_pc;
                st_d.mask    = top_mask;
                st_d.join_pc = top_join;
            end else if (br_i) begin
                unique case (kind)
                    BK_ALL_TAKEN: st_d.pc = br_target;
                    BK_SPLIT: begin
                        if (room2) begin
                            push_w       = 1'b1;
                            st_d.pc      = br_target;
                            st_d.mask    = taken_m;
                            st_d.join_pc = br_reconv;
                        end else begin
                            st_d.err = 1'b1;
                            st_d.pc  = br_fallthru;
                        end
                    end
                    default: st_d.pc = br_fallthru;
                endcase
            end else begin
                st_d.pc = cur_pc + PC_W'(PC_STEP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc      <= '0;
            st_q.mask    <= '1;
            st_q.join_pc <= '0;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc     = st_q.pc;
    assign active_mask = st_q.mask;
    assign ovf_err     = st_q.err;

    // R1
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) active_mask != '0);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |=> ovf_err);

    // R5
    branch_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && br_i && !pop_w) |=> ((active_mask & ~$past(active_mask)) == '0));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(next_pc) && $stable(active_mask) && $stable(ovf_err));

endmodule

// File: tb/warp_diverge_unit_bench.sv
`timescale 1ns/1ps
module warp_diverge_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, br_i = 1'b0;
    logic [31:0] cur_pc = '0, br_vote = '0, br_target = '0, br_fallthru = '0, br_reconv = '0;
    logic [31:0] next_pc, active_mask;
    logic        ovf_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    warp_diverge_unit #(.LANES(32), .PC_W(32), .DEPTH(4), .PC_STEP(4)) u_warp_diverge_unit (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_i(br_i), .cur_pc(cur_pc),
        .br_vote(br_vote), .br_target(br_target), .br_fallthru(br_fallthru),
        .br_reconv(br_reconv), .next_pc(next_pc), .active_mask(active_mask), .ovf_err(ovf_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic expect_state(input string tag, input logic [31:0] pc, input logic [31:0] m);
        chk({tag, " pc"}, next_pc, pc);
        chk({tag, " mask"}, active_mask, m);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step_i = 1'b0;
        br_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Sequential step at pc: result visible at the next falling edge.
    task automatic seq(input logic [31:0] pc);
        @(negedge clk);
        step_i = 1'b1; br_i = 1'b0; cur_pc = pc;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic branch(input logic [31:0] pc, input logic [31:0] v,
                          input logic [31:0] t, input logic [31:0] f, input logic [31:0] r);
        @(negedge clk);
        step_i = 1'b1; br_i = 1'b1; cur_pc = pc;
        br_vote = v; br_target = t; br_fallthru = f; br_reconv = r;
        @(negedge clk);
        step_i = 1'b0; br_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_state("R1 reset", 32'h0, 32'hFFFF_FFFF);
        chk("R1 err", {31'b0, ovf_err}, 32'h0);
    endtask

    task automatic t_sequential();
        do_reset();
        seq(32'h100);
        expect_state("R2 seq", 32'h104, 32'hFFFF_FFFF);
        @(negedge clk);
        expect_state("R13 idle hold", 32'h104, 32'hFFFF_FFFF);
    endtask

    task automatic t_uniform();
        do_reset();
        branch(32'h104, 32'hFFFF_FFFF, 32'h200, 32'h108, 32'h300);
        expect_state("R3 all taken", 32'h200, 32'hFFFF_FFFF);
        seq(32'h300);
        expect_state("R3 no push", 32'h304, 32'hFFFF_FFFF);
        branch(32'h304, 32'h0, 32'h400, 32'h308, 32'h500);
        expect_state("R4 all fall", 32'h308, 32'hFFFF_FFFF);
        seq(32'h500);
        expect_state("R4 no push", 32'h504, 32'hFFFF_FFFF);
    endtask

    task automatic t_diverge();
        do_reset();
        branch(32'h10, 32'h0000_FFFF, 32'h40, 32'h14, 32'h80);
        expect_state("R5 split", 32'h40, 32'h0000_FFFF);
        seq(32'h40);
        expect_state("R2 in path", 32'h44, 32'h0000_FFFF);
        // inactive upper lanes vote taken, live lanes all not-taken
        branch(32'h44, 32'hABCD_0000, 32'h70, 32'h48, 32'h60);
        expect_state("R9 inactive ignored", 32'h48, 32'h0000_FFFF);
        seq(32'h80);
        expect_state("R6 taken end", 32'h14, 32'hFFFF_0000);
        seq(32'h80);
        expect_state("R7 reconverge", 32'h80, 32'hFFFF_FFFF);
        seq(32'h80);
        expect_state("R7 stack empty", 32'h84, 32'hFFFF_FFFF);
    endtask

    task automatic t_nested();
        do_reset();
        branch(32'h10, 32'h00FF_00FF, 32'h40, 32'h14, 32'h80);
        expect_state("R8 outer", 32'h40, 32'h00FF_00FF);
        branch(32'h40, 32'hFFFF_000F, 32'h50, 32'h44, 32'h60);
        expect_state("R8 inner R9", 32'h50, 32'h00FF_000F);
        seq(32'h60);
        expect_state("R8 inner fall", 32'h44, 32'h0000_00F0);
        seq(32'h60);
        expect_state("R8 inner join", 32'h60, 32'h00FF_00FF);
        seq(32'h80);
        expect_state("R8 outer fall", 32'h14, 32'hFF00_FF00);
        seq(32'h80);
        expect_state("R8 outer join", 32'h80, 32'hFFFF_FFFF);
    endtask

    task automatic t_precedence();
        do_reset();
        branch(32'h10, 32'h0000_000F, 32'h40, 32'h14, 32'h80);
        expect_state("R12 setup", 32'h40, 32'h0000_000F);
        branch(32'h80, 32'h0000_0001, 32'h90, 32'h84, 32'hA0);
        expect_state("R12 join wins", 32'h14, 32'hFFFF_FFF0);
        seq(32'h80);
        expect_state("R12 restore", 32'h80, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow();
        do_reset();
        branch(32'h10, 32'h0000_FFFF, 32'h40, 32'h14, 32'h80);
        branch(32'h40, 32'h0000_00FF, 32'h50, 32'h44, 32'h60);
        expect_state("R10 two levels", 32'h50, 32'h0000_00FF);
        chk("R10 no err yet", {31'b0, ovf_err}, 32'h0);
        branch(32'h50, 32'h0000_000F, 32'h58, 32'h54, 32'h5C);
        expect_state("R10 refused", 32'h54, 32'h0000_00FF);
        chk("R10 err set", {31'b0, ovf_err}, 32'h1);
        seq(32'h60);
        expect_state("R10 unwind1", 32'h44, 32'h0000_FF00);
        seq(32'h60);
        expect_state("R10 unwind2", 32'h60, 32'h0000_FFFF);
        seq(32'h80);
        expect_state("R10 unwind3", 32'h14, 32'hFFFF_0000);
        seq(32'h80);
        expect_state("R10 unwind4", 32'h80, 32'hFFFF_FFFF);
        chk("R11 err sticky", {31'b0, ovf_err}, 32'h1);
        do_reset();
        chk("R11 err cleared by reset", {31'b0, ovf_err}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_uniform();
        t_diverge();
        t_nested();
        t_precedence();
        t_overflow();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule